// File: doc/BRIEF.md
# Two-Step Power-Gate Wake Sequencer

This controller gates the word-line driver rails of a nonvolatile memory array, one gating segment for every 128 rows. Each segment owns two switch enables: one ties its driver rail to the chip supply, the other to the regulated supply. On a wake request the addressed segment first precharges its rail from the chip supply. It then hands the rail over to the regulator with a single cycle where both switches are closed. After a settle interval it reports itself ready for reads. This keeps the regulator's inrush small.

Phase lengths come from two configuration inputs, clamped so that the whole sequence fits inside a fixed cycle budget. That budget corresponds to the sub-100 ns wake limit at the design clock. A global standby input opens every switch at once. Per-segment sleep requests turn a single segment off, but never in the middle of its wake sequence. Reads aimed at a segment that is not ready are stalled.

Top module: `pg_wake_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every chip-supply enable, regulated enable and ready flag is 0.
- R2: A wake request to a segment that is off closes its chip-supply switch at the next edge. That switch is held alone for P cycles. P is the precharge setting, with 0 read as 1 and any value above MAX_PHASE (23 by default) read as MAX_PHASE. The regulated switch stays open throughout.
- R3: After precharge, both switches of the segment are closed for exactly one clock cycle. The chip-supply switch then opens while the regulated switch stays closed.
- R4: The regulated switch is then held alone for S cycles, with S clamped like P, before the ready flag rises. A ready segment has its regulated switch closed and its chip-supply switch open.
- R5: With the tick held high, the time from the wake edge to ready is P+S+1 cycles. This never exceeds the budget SEQ_BUDGET_CYC (48 by default).
- R6: Precharge and settle counts advance only on cycles with tick_i high. The one-cycle overlap does not wait for a tick.
- R7: One edge after standby_i is high, both switches and the ready flag of every segment are 0, including segments in mid-sequence. Wake requests are ignored while standby_i is high.
- R8: A sleep request to a ready segment turns it fully off at the next edge. A sleep request that arrives during the segment's wake sequence is held: the segment reaches ready, shows ready for exactly one cycle, then turns off.
- R9: A wake request to a segment that is not off has no effect, and a sleep request to a segment that is off has no effect.
- R10: read_stall_o is high in the same cycle exactly when read_req_i is high and the segment selected by read_seg_i is not ready.
- R11: Segments sequence independently: requests addressed to one segment leave the outputs of every other segment unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Low-power standby, opens all switches |
| wake_req_i | input | 1 | Wake request for seg_sel_i |
| sleep_req_i | input | 1 | Sleep request for seg_sel_i |
| seg_sel_i | input | SEG_W | Target segment of a wake or sleep request |
| pre_cfg_i | input | CFG_W | Precharge length setting, in ticks |
| settle_cfg_i | input | CFG_W | Settle length setting, in ticks |
| tick_i | input | 1 | Timer tick enabling the phase counters |
| read_req_i | input | 1 | Read request |
| read_seg_i | input | SEG_W | Segment addressed by the read |
| main_en_o | output | NUM_SEG | Chip-supply switch enable per segment |
| reg_en_o | output | NUM_SEG | Regulated-supply switch enable per segment |
| ready_o | output | NUM_SEG | Segment ready for reads |
| read_stall_o | output | 1 | Read must wait |

## Verification
The assertions take for granted that the two length settings stay constant while any segment is sequencing. They also assume wake and sleep are never raised together for the same segment, and that seg_sel_i and read_seg_i stay below NUM_SEG. The stimulus changes settings only while every segment is idle or ready, pulses one request at a time, and uses only valid segment indices. The tick is held high except in a dedicated run that drops it during precharge and settle.

// File: rtl/pg_wake_pkg.sv
package pg_wake_pkg;
  typedef enum logic [2:0] {
    SEG_OFF,
    SEG_PRE,
    SEG_OVL,
    SEG_SETTLE,
    SEG_ON
  } seg_state_e;
endpackage

// File: rtl/pg_cfg_clamp.sv
module pg_cfg_clamp #(
  parameter int CFG_W   = 6,
  parameter int CNT_W   = 5,
  parameter int MAX_VAL = 23
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CNT_W-1:0] len_o
);
  always_comb begin
    if (cfg_i == '0)                   len_o = CNT_W'(1);
    else if (cfg_i > CFG_W'(MAX_VAL))  len_o = CNT_W'(MAX_VAL);
    else                               len_o = cfg_i[CNT_W-1:0];
  end
endmodule

// File: rtl/pg_phase_cnt.sv
module pg_phase_cnt #(
  parameter int CNT_W   = 5,
  parameter int MAX_VAL = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (tick_i && cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
  end

  // last tick of a phase
  assign done_o = tick_i && (cnt_q <= CNT_W'(1));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_VAL));
endmodule

// File: rtl/pg_seg_ctrl.sv
module pg_seg_ctrl
  import pg_wake_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int MAX_VAL = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic             sleep_i,
  input  logic             standby_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] pre_len_i,
  input  logic [CNT_W-1:0] settle_len_i,
  output logic             main_en_o,
  output logic             reg_en_o,
  output logic             ready_o
);
  seg_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       load_pre, load_set, done;

  assign load_pre = (state_q == SEG_OFF) && wake_i && !standby_i;
  assign load_set = (state_q == SEG_OVL) && !standby_i;

  pg_phase_cnt #(.CNT_W(CNT_W), .MAX_VAL(MAX_VAL)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_pre || load_set),
    .load_val_i (load_pre ? pre_len_i : settle_len_i),
    .tick_i     (tick_i),
    .done_o     (done)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      SEG_OFF:    if (wake_i) state_d = SEG_PRE;
      SEG_PRE:    if (done)   state_d = SEG_OVL;
      SEG_OVL:                state_d = SEG_SETTLE;
      SEG_SETTLE: if (done)   state_d = SEG_ON;
      SEG_ON: begin
        if (sleep_i || pend_q) state_d = SEG_OFF;
        pend_d = 1'b0;
      end
      default:                state_d = SEG_OFF;
    endcase
    // sleep during a wake is deferred to the ready state
    if (sleep_i && (state_q inside {SEG_PRE, SEG_OVL, SEG_SETTLE})) pend_d = 1'b1;
    if (standby_i) begin
      state_d = SEG_OFF;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEG_OFF;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign main_en_o = (state_q == SEG_PRE) || (state_q == SEG_OVL);
  assign reg_en_o  = (state_q == SEG_OVL) || (state_q == SEG_SETTLE) || (state_q == SEG_ON);
  assign ready_o   = (state_q == SEG_ON);

  p_pre_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_en_o) |-> $past(main_en_o) && main_en_o);
  p_ovl_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_en_o && reg_en_o) |=> !main_en_o);
  p_no_float_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_en_o) |-> (reg_en_o || $past(standby_i)));
  p_ready_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (reg_en_o && !main_en_o));
  p_standby_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!main_en_o && !reg_en_o && !ready_o));
  p_sleep_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sleep_i) |=> !ready_o && !reg_en_o);
endmodule

// File: rtl/pg_wake_seq.sv
module pg_wake_seq #(
  parameter int NUM_SEG        = 4,
  parameter int CFG_W          = 6,
  parameter int SEQ_BUDGET_CYC = 48,
  localparam int SEG_W         = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               standby_i,
  input  logic               wake_req_i,
  input  logic               sleep_req_i,
  input  logic [SEG_W-1:0]   seg_sel_i,
  input  logic [CFG_W-1:0]   pre_cfg_i,
  input  logic [CFG_W-1:0]   settle_cfg_i,
  input  logic               tick_i,
  input  logic               read_req_i,
  input  logic [SEG_W-1:0]   read_seg_i,
  output logic [NUM_SEG-1:0] main_en_o,
  output logic [NUM_SEG-1:0] reg_en_o,
  output logic [NUM_SEG-1:0] ready_o,
  output logic               read_stall_o
);
  // precharge + overlap + settle must fit the budget
  localparam int MAX_PHASE = (SEQ_BUDGET_CYC - 1) / 2;
  localparam int CNT_W     = $clog2(MAX_PHASE + 1);

  logic [CNT_W-1:0] pre_len, settle_len;

  pg_cfg_clamp #(.CFG_W(CFG_W), .CNT_W(CNT_W), .MAX_VAL(MAX_PHASE)) u_pre_clamp (
    .cfg_i (pre_cfg_i),
    .len_o (pre_len)
  );

  pg_cfg_clamp #(.CFG_W(CFG_W), .CNT_W(CNT_W), .MAX_VAL(MAX_PHASE)) u_settle_clamp (
    .cfg_i (settle_cfg_i),
    .len_o (settle_len)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = (seg_sel_i == SEG_W'(g));

    pg_seg_ctrl #(.CNT_W(CNT_W), .MAX_VAL(MAX_PHASE)) u_seg (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wake_i       (wake_req_i && hit && !standby_i),
      .sleep_i      (sleep_req_i && hit),
      .standby_i    (standby_i),
      .tick_i       (tick_i),
      .pre_len_i    (pre_len),
      .settle_len_i (settle_len),
      .main_en_o    (main_en_o[g]),
      .reg_en_o     (reg_en_o[g]),
      .ready_o      (ready_o[g])
    );
  end

  assign read_stall_o = read_req_i && !ready_o[read_seg_i];

  p_standby_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (main_en_o == '0) && (reg_en_o == '0) && (ready_o == '0));
  p_ready_one_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & main_en_o) == '0);
endmodule

// File: tb/pg_wake_seq_tb.sv
module pg_wake_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int CFG_W  = 6;
  localparam int BUDGET = 48;
  localparam int MAXP   = (BUDGET - 1) / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic standby = 1'b0, wake = 1'b0, sleep = 1'b0, tick = 1'b1, rreq = 1'b0;
  logic [1:0] sel = '0, rseg = '0;
  logic [CFG_W-1:0] pre_cfg = '0, set_cfg = '0;
  logic [N-1:0] main_en, reg_en, ready;
  logic stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_wake_seq #(.NUM_SEG(N), .CFG_W(CFG_W), .SEQ_BUDGET_CYC(BUDGET)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .standby_i(standby), .wake_req_i(wake),
    .sleep_req_i(sleep), .seg_sel_i(sel), .pre_cfg_i(pre_cfg),
    .settle_cfg_i(set_cfg), .tick_i(tick), .read_req_i(rreq),
    .read_seg_i(rseg), .main_en_o(main_en), .reg_en_o(reg_en),
    .ready_o(ready), .read_stall_o(stall)
  );

  typedef struct {
    logic [N-1:0] m;
    logic [N-1:0] r;
    logic [N-1:0] y;
    string        tag;
  } item_t;

  item_t q[$];
  logic [N-1:0] exp_m = '0, exp_r = '0, exp_y = '0;
  int n_cmp = 0, n_mis = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({main_en, reg_en, ready} === {it.m, it.r, it.y}, it.tag,
          32'({main_en, reg_en, ready}), 32'({it.m, it.r, it.y}));
    end
  end

  task automatic step(string tag);
    @(posedge clk);
    #1;
    q.push_back('{exp_m, exp_r, exp_y, tag});
  endtask

  function automatic int eff(int v);
    if (v == 0) return 1;
    if (v > MAXP) return MAXP;
    return v;
  endfunction

  task automatic wake_seq(int s, int pc, int sc, string tag);
    int np, ns;
    np = eff(pc);
    ns = eff(sc);
    chk(np + ns + 1 <= BUDGET, "R5 budget", 32'(np + ns + 1), 32'(BUDGET));
    pre_cfg = CFG_W'(pc);
    set_cfg = CFG_W'(sc);
    wake = 1'b1; sel = 2'(s);
    exp_m[s] = 1'b1;
    step({tag, " R2 pre"});
    wake = 1'b0;
    repeat (np - 1) step({tag, " R2 pre"});
    exp_r[s] = 1'b1;
    step({tag, " R3 overlap"});
    exp_m[s] = 1'b0;
    repeat (ns) step({tag, " R4 settle"});
    exp_y[s] = 1'b1;
    step({tag, " R4 ready"});
  endtask

  task automatic stall_chk(int s, bit expv, string tag);
    rreq = 1'b1; rseg = 2'(s);
    #1;
    chk(stall === expv, tag, 32'(stall), 32'(expv));
    rreq = 1'b0;
  endtask

  task automatic all_off();
    exp_m = '0; exp_r = '0; exp_y = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    // R1 reset
    #(CLK_PERIOD + 3);
    chk({main_en, reg_en, ready} === '0, "R1 in reset", 32'({main_en, reg_en, ready}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    step("R1 after reset");

    // R2 R3 R4 basic sequence
    wake_seq(0, 3, 4, "seg0");

    // R10 stall
    stall_chk(0, 1'b0, "R10 ready seg no stall");
    stall_chk(1, 1'b1, "R10 off seg stall");
    #1;
    chk(stall === 1'b0, "R10 no request", 32'(stall), 0);

    // R9 wake to ready segment, sleep to off segment
    wake = 1'b1; sel = 2'd0;
    step("R9 wake ignored");
    wake = 1'b0;
    sleep = 1'b1; sel = 2'd2;
    step("R9 sleep ignored");
    sleep = 1'b0;

    // R2 R5 clamp: 0 -> 1, 60 -> MAXP; R11 seg0 stays ready
    wake_seq(1, 0, 60, "seg1 clamp R11");

    // R8 sleep on ready segment
    sleep = 1'b1; sel = 2'd0;
    exp_m[0] = 1'b0; exp_r[0] = 1'b0; exp_y[0] = 1'b0;
    step("R8 sleep ready");
    sleep = 1'b0;
    stall_chk(0, 1'b1, "R10 after sleep stall");

    // R8 sleep during wake held
    pre_cfg = 6'd2; set_cfg = 6'd2;
    wake = 1'b1; sel = 2'd2;
    exp_m[2] = 1'b1;
    step("R8 pre");
    wake = 1'b0; sleep = 1'b1;
    step("R8 pre held");
    sleep = 1'b0;
    exp_r[2] = 1'b1;
    step("R8 overlap");
    exp_m[2] = 1'b0;
    repeat (2) step("R8 settle");
    exp_y[2] = 1'b1;
    step("R8 ready one cycle");
    exp_r[2] = 1'b0; exp_y[2] = 1'b0;
    step("R8 deferred off");

    // R6 tick gating on seg3, pre 3 settle 2
    pre_cfg = 6'd3; set_cfg = 6'd2;
    wake = 1'b1; sel = 2'd3;
    exp_m[3] = 1'b1;
    step("R6 pre entry");
    wake = 1'b0; tick = 1'b0;
    repeat (4) step("R6 pre held no tick");
    tick = 1'b1;
    repeat (2) step("R6 pre");
    exp_r[3] = 1'b1;
    step("R6 overlap");
    tick = 1'b0;
    exp_m[3] = 1'b0;
    step("R6 overlap needs no tick");
    repeat (3) step("R6 settle held no tick");
    tick = 1'b1;
    step("R6 settle");
    exp_y[3] = 1'b1;
    step("R6 ready");

    // R7 standby with concurrent wake
    standby = 1'b1; wake = 1'b1; sel = 2'd0;
    all_off();
    step("R7 standby all open");
    step("R7 wake ignored in standby");
    standby = 1'b0; wake = 1'b0;
    step("R7 stays off");

    // R7 standby aborts a wake
    pre_cfg = 6'd5; set_cfg = 6'd1;
    wake = 1'b1; sel = 2'd0;
    exp_m[0] = 1'b1;
    step("R7 pre before abort");
    wake = 1'b0; standby = 1'b1;
    exp_m[0] = 1'b0;
    step("R7 abort");
    standby = 1'b0;
    step("R7 remains off");

    // R11 independent sequences
    wake_seq(1, 2, 2, "seg1 R11");
    wake_seq(2, 1, 1, "seg2 R11");
    stall_chk(2, 1'b0, "R10 seg2 ready");
    wake_seq(0, 23, 23, "seg0 max R5");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule